// File: doc/BRIEF.md
# Cascadable Reload Timer Pair with PWM

This block holds two 8-bit down-counters, timer A and timer B, that share one register port. Each timer keeps a reload latch next to its counter. When a counter that already reads 00 receives one more count pulse it underflows: it takes the latch value again and carries on counting. Every underflow sends a one-cycle interrupt request, and it can also flip a divide-by-two square-wave output.

Timer A counts the system clock divided by 16, 32 or 128. Timer B counts one of three things: timer A's underflows, a slow tick input divided by 16, or an external count pin. That pin is synchronized, and the edge it counts on can be chosen. Timer B also has a PWM mode. In that mode its latch gives the number of high counts and a separate low-time register gives the number of low counts. An interrupt is raised at each rising edge of this output.

Software writes a timer address to load the latch, and the counter too while that timer is stopped. It reads the live counts back at the same addresses.

Top module: `tmr_pair_pwm`

## Requirements
- R1: A running timer counts down by one on each count pulse. A pulse that arrives while the count is 00 reloads the latch value. For example, latch 2 gives 2, 1, 0, 2, 1.
- R2: Each underflow pulses that timer's interrupt output (`irq_a`, `irq_b`) high for exactly one clock, on the same edge as the reload.
- R3: While a timer's stop bit is 1 its count ignores count pulses. Clearing the bit resumes counting from the held value. Stop bits are control register (address 3) bit 4 for timer A and bit 5 for timer B.
- R4: Timer A source, control bits [1:0]: 00 = clock/16, 01 = clock/32, 10 = clock/128, 11 = no counting.
- R5: Timer B source, control bits [3:2]: 00 = timer A underflow, 01 = `slow_tick` pulses divided by 16, 10 = external pin `cnt_pin`, 11 = no counting.
- R6: When timer B counts the pin, it counts one pulse per selected edge. Output register (address 4) bit 3 selects the edge: 1 = rising, 0 = falling. The other edge has no effect.
- R7: With output register bit 0 (timer A) or bit 1 (timer B) set, the timer's output flips on every underflow. With the bit clear, the output stays low.
- R8: With output register bit 2 set, timer B runs in PWM mode. Its output is high for n count pulses and low for m count pulses, where n is the timer B latch and m is the low-time register (address 2). Entering the mode starts a low phase that ends when the counter reaches 1 (or is already 0 or 1) at a count pulse.
- R9: In PWM mode the output stays low when n = 0 and stays high when m = 0 with n non-zero. The n = 0 case wins when both are zero.
- R10: In PWM mode, `irq_b` pulses for one clock on each rising edge of the output.
- R11: After reset, timer A and its latch read FF, timer B and its latch read 01, and the control, output and low-time registers read 00.
- R12: A write to a timer address while that timer is stopped loads both latch and counter. While it is running the write loads only the latch, and the new value shows at the next reload.
- R13: The read map is: 0 = timer A count, 1 = timer B count, 2 = low-time register, 3 = control register, 4 = output register. Other addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address |
| wr_data | input | 8 | Write data |
| rd_addr | input | 3 | Read address |
| rd_data | output | 8 | Read data, combinational from rd_addr |
| slow_tick | input | 1 | One-cycle enable from a slow time base |
| cnt_pin | input | 1 | External count pin, asynchronous |
| out_a | output | 1 | Timer A square-wave output |
| out_b | output | 1 | Timer B square-wave or PWM output |
| irq_a | output | 1 | Timer A underflow request pulse |
| irq_b | output | 1 | Timer B underflow or PWM rising-edge request pulse |

## Verification
A change on `cnt_pin` reaches timer B's counter at the third rising clock edge: two synchronizer stages, then the count register. Every pin stimulus is therefore held for five clocks before the bench looks at counts, outputs or request totals. Register writes take effect at the next edge. Reads are combinational, and the bench samples them just after a falling edge.

The prescaled clock sources run freely, so their checks are phase-free. They compare two reads taken exactly one divide period apart, or an exact multiple of it, and count `irq_a` pulses over the same window. The bench samples request pulses on every falling edge and adds them to tallies, which are compared with the model totals.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam logic [2:0] ADR_TMR_A = 3'd0;
  localparam logic [2:0] ADR_TMR_B = 3'd1;
  localparam logic [2:0] ADR_LOW   = 3'd2;
  localparam logic [2:0] ADR_CTRL  = 3'd3;
  localparam logic [2:0] ADR_OUTC  = 3'd4;

  typedef enum logic [1:0] {
    SRCA_DIV_LO  = 2'b00,
    SRCA_DIV_MID = 2'b01,
    SRCA_DIV_HI  = 2'b10,
    SRCA_NONE    = 2'b11
  } src_a_e;

  typedef enum logic [1:0] {
    SRCB_CHAIN = 2'b00,
    SRCB_SLOW  = 2'b01,
    SRCB_PIN   = 2'b10,
    SRCB_NONE  = 2'b11
  } src_b_e;
endpackage

// File: rtl/tmr_divider.sv
module tmr_divider #(
  parameter int DIV = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic pulse
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q, cnt_n;

  always_comb begin
    cnt_n = cnt_q;
    if (en) cnt_n = (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_n;
  end

  assign pulse = en && (cnt_q == LAST);
endmodule

// File: rtl/tmr_pin_edge.sv
module tmr_pin_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  input  logic rise_sel,
  output logic pulse
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], pin};
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign pulse = rise_sel ? (sync_q[STAGES-1] && !prev_q)
                          : (!sync_q[STAGES-1] && prev_q);

  // R6: a detected edge lasts a single cycle
  p_edge_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    pulse |=> !pulse);
endmodule

// File: rtl/tmr_core.sv
module tmr_core #(
  parameter int          W         = 8,
  parameter bit          PWM_EN    = 1'b0,
  parameter logic [W-1:0] RESET_VAL = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         stop,
  input  logic         wr_cnt,
  input  logic [W-1:0] wr_data,
  input  logic         out_en,
  input  logic         pwm_mode,
  input  logic [W-1:0] low_time,
  output logic [W-1:0] cnt,
  output logic         out,
  output logic         irq
);
  localparam logic [W-1:0] ONE = W'(1);

  logic [W-1:0] cnt_q, cnt_n, latch_q, latch_n;
  logic         hi_q, hi_n, tgl_q, tgl_n, out_q, out_n, irq_q, irq_n;
  logic         run, pwm_act, uf, at_end;

  assign pwm_act = PWM_EN && pwm_mode;
  assign run     = tick && !stop;
  assign at_end  = (cnt_q <= ONE);
  assign uf      = run && !pwm_act && (cnt_q == '0);

  always_comb begin
    latch_n = wr_cnt ? wr_data : latch_q;
    cnt_n   = cnt_q;
    hi_n    = pwm_act ? hi_q : 1'b0;
    if (wr_cnt && stop) begin
      cnt_n = wr_data;
    end else if (run) begin
      if (pwm_act) begin
        if (at_end) begin
          hi_n  = !hi_q;
          cnt_n = hi_q ? low_time : latch_q;
        end else begin
          cnt_n = cnt_q - 1'b1;
        end
      end else begin
        cnt_n = uf ? latch_q : cnt_q - 1'b1;
      end
    end
    tgl_n = (!out_en || pwm_act) ? 1'b0 : (uf ? !tgl_q : tgl_q);
    if (!pwm_act)               out_n = tgl_n;
    else if (latch_q == '0)     out_n = 1'b0;
    else if (low_time == '0)    out_n = 1'b1;
    else                        out_n = hi_n;
    irq_n = pwm_act ? (out_n && !out_q) : uf;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= RESET_VAL;
      latch_q <= RESET_VAL;
      hi_q    <= 1'b0;
      tgl_q   <= 1'b0;
      out_q   <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      cnt_q   <= cnt_n;
      latch_q <= latch_n;
      hi_q    <= hi_n;
      tgl_q   <= tgl_n;
      out_q   <= out_n;
      irq_q   <= irq_n;
    end
  end

  assign cnt = cnt_q;
  assign out = out_q;
  assign irq = irq_q;

  p_stop_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (stop && !wr_cnt) |=> (cnt_q == $past(cnt_q)));
  p_reload_r1: assert property (@(posedge clk) disable iff (!rst_n)
    uf |=> (cnt_q == $past(latch_q)));
  p_irq_on_uf_r2: assert property (@(posedge clk) disable iff (!rst_n)
    uf |=> irq_q);
  p_toggle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (uf && out_en) |=> (out_q != $past(out_q)));
  p_pwm_zero_high_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (pwm_act && latch_q == '0) |=> !out_q);
  p_pwm_zero_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (pwm_act && latch_q != '0 && low_time == '0) |=> out_q);
endmodule

// File: rtl/tmr_pair_pwm.sv
module tmr_pair_pwm #(
  parameter int W        = 8,
  parameter int DIV_LO   = 16,
  parameter int DIV_MID  = 32,
  parameter int DIV_HI   = 128,
  parameter int SLOW_DIV = 16,
  parameter int SYNC_LEN = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [2:0]   wr_addr,
  input  logic [W-1:0] wr_data,
  input  logic [2:0]   rd_addr,
  output logic [W-1:0] rd_data,
  input  logic         slow_tick,
  input  logic         cnt_pin,
  output logic         out_a,
  output logic         out_b,
  output logic         irq_a,
  output logic         irq_b
);
  import tmr_pkg::*;

  logic [1:0]   rst_sync_q;
  logic         rst_i;
  logic [W-1:0] ctrl_q, ctrl_n, outc_q, outc_n, low_q, low_n;
  logic         p_lo, p_mid, p_hi, p_slow, p_pin;
  logic         tick_a, tick_b, wr_ta, wr_tb;
  logic [W-1:0] cnt_a, cnt_b;
  src_a_e       src_a;
  src_b_e       src_b;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i = rst_sync_q[1];

  assign wr_ta = wr_en && (wr_addr == ADR_TMR_A);
  assign wr_tb = wr_en && (wr_addr == ADR_TMR_B);

  always_comb begin
    ctrl_n = ctrl_q;
    outc_n = outc_q;
    low_n  = low_q;
    if (wr_en) begin
      case (wr_addr)
        ADR_CTRL: ctrl_n = wr_data;
        ADR_OUTC: outc_n = wr_data;
        ADR_LOW:  low_n  = wr_data;
        default:  ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      ctrl_q <= '0;
      outc_q <= '0;
      low_q  <= '0;
    end else begin
      ctrl_q <= ctrl_n;
      outc_q <= outc_n;
      low_q  <= low_n;
    end
  end

  assign src_a = src_a_e'(ctrl_q[1:0]);
  assign src_b = src_b_e'(ctrl_q[3:2]);

  tmr_divider #(.DIV(DIV_LO))   u_div_lo   (.clk(clk), .rst_n(rst_i), .en(1'b1),      .pulse(p_lo));
  tmr_divider #(.DIV(DIV_MID))  u_div_mid  (.clk(clk), .rst_n(rst_i), .en(1'b1),      .pulse(p_mid));
  tmr_divider #(.DIV(DIV_HI))   u_div_hi   (.clk(clk), .rst_n(rst_i), .en(1'b1),      .pulse(p_hi));
  tmr_divider #(.DIV(SLOW_DIV)) u_div_slow (.clk(clk), .rst_n(rst_i), .en(slow_tick), .pulse(p_slow));

  tmr_pin_edge #(.STAGES(SYNC_LEN)) u_pin (
    .clk(clk), .rst_n(rst_i), .pin(cnt_pin), .rise_sel(outc_q[3]), .pulse(p_pin));

  always_comb begin
    case (src_a)
      SRCA_DIV_LO:  tick_a = p_lo;
      SRCA_DIV_MID: tick_a = p_mid;
      SRCA_DIV_HI:  tick_a = p_hi;
      default:      tick_a = 1'b0;
    endcase
    case (src_b)
      SRCB_CHAIN: tick_b = irq_a;
      SRCB_SLOW:  tick_b = p_slow;
      SRCB_PIN:   tick_b = p_pin;
      default:    tick_b = 1'b0;
    endcase
  end

  tmr_core #(.W(W), .PWM_EN(1'b0), .RESET_VAL({W{1'b1}})) u_tmr_a (
    .clk(clk), .rst_n(rst_i), .tick(tick_a), .stop(ctrl_q[4]),
    .wr_cnt(wr_ta), .wr_data(wr_data), .out_en(outc_q[0]),
    .pwm_mode(1'b0), .low_time(low_q), .cnt(cnt_a), .out(out_a), .irq(irq_a));

  tmr_core #(.W(W), .PWM_EN(1'b1), .RESET_VAL(W'(1))) u_tmr_b (
    .clk(clk), .rst_n(rst_i), .tick(tick_b), .stop(ctrl_q[5]),
    .wr_cnt(wr_tb), .wr_data(wr_data), .out_en(outc_q[1]),
    .pwm_mode(outc_q[2]), .low_time(low_q), .cnt(cnt_b), .out(out_b), .irq(irq_b));

  always_comb begin
    case (rd_addr)
      ADR_TMR_A: rd_data = cnt_a;
      ADR_TMR_B: rd_data = cnt_b;
      ADR_LOW:   rd_data = low_q;
      ADR_CTRL:  rd_data = ctrl_q;
      ADR_OUTC:  rd_data = outc_q;
      default:   rd_data = '0;
    endcase
  end

  // R5: with the chained source, timer B sees at most one count per timer A request
  p_chain_single_r5: assert property (@(posedge clk) disable iff (!rst_i)
    (src_b == SRCB_CHAIN && irq_a) |=> !irq_a);
endmodule

// File: tb/tmr_pair_pwm_tb.sv
module tmr_pair_pwm_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [2:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic       slow_tick = 1'b0;
  logic       cnt_pin = 1'b0;
  logic       out_a, out_b, irq_a, irq_b;

  int n_tests = 0;
  int n_fail  = 0;
  int irqa_tot = 0;
  int irqb_tot = 0;
  bit done = 1'b0;

  // bench model of timer B
  int m_cnt, m_latch, m_low, m_irq;
  bit m_tgl, m_hi;

  always #2ns clk = ~clk;

  tmr_pair_pwm u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .slow_tick(slow_tick), .cnt_pin(cnt_pin),
    .out_a(out_a), .out_b(out_b), .irq_a(irq_a), .irq_b(irq_b));

  always @(negedge clk) begin
    if (irq_a) irqa_tot++;
    if (irq_b) irqb_tot++;
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output int v);
    @(negedge clk);
    rd_addr = a;
    #1ns;
    v = int'(rd_data);
  endtask

  task automatic pin_pulse();
    @(negedge clk); cnt_pin = 1'b1;
    repeat (5) @(negedge clk);
    cnt_pin = 1'b0;
    repeat (5) @(negedge clk);
  endtask

  task automatic slow_pulses(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); slow_tick = 1'b1;
      @(negedge clk); slow_tick = 1'b0;
    end
  endtask

  // R1/R2/R7: expected reaction of a normal-mode timer to one count pulse
  function automatic void step_norm();
    if (m_cnt == 0) begin
      m_cnt = m_latch; m_tgl = !m_tgl; m_irq++;
    end else m_cnt--;
  endfunction

  // R8/R10: expected reaction of the PWM timer to one count pulse
  function automatic void step_pwm();
    if (m_cnt <= 1) begin
      if (!m_hi) begin m_hi = 1'b1; m_cnt = m_latch; m_irq++; end
      else       begin m_hi = 1'b0; m_cnt = m_low; end
    end else m_cnt--;
  endfunction

  initial begin
    #(200000 * 4ns);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    int v, v2, ia, ib, seed;
    seed = $urandom(32'h5EED_0042);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R11 reset values, R13 read map
    rd(3'd0, v); chk("R11 timer A reset", v, 8'hFF);
    rd(3'd1, v); chk("R11 timer B reset", v, 8'h01);
    rd(3'd2, v); chk("R11 low-time reset", v, 0);
    rd(3'd3, v); chk("R11 control reset", v, 0);
    rd(3'd4, v); chk("R11 output reg reset", v, 0);
    rd(3'd7, v); chk("R13 unmapped read", v, 0);
    chk("R7 out_a low when disabled", int'(out_a), 0);

    // R4 timer A sources
    rd(3'd0, v); repeat (15) @(negedge clk); rd(3'd0, v2);
    chk("R4 clock/16", v - v2, 1);
    wr(3'd3, 8'h01);
    rd(3'd0, v); repeat (31) @(negedge clk); rd(3'd0, v2);
    chk("R4 clock/32", v - v2, 1);
    wr(3'd3, 8'h02);
    rd(3'd0, v); repeat (127) @(negedge clk); rd(3'd0, v2);
    chk("R4 clock/128", v - v2, 1);
    wr(3'd3, 8'h03);
    rd(3'd0, v); repeat (300) @(negedge clk); rd(3'd0, v2);
    chk("R4 code 11 holds", v2, v);
    rd(3'd3, v); chk("R13 control readback", v, 8'h03);

    // R12 stopped writes load counter; R5 chain; R2 request count
    wr(3'd3, 8'h30);
    wr(3'd0, 8'd3);
    wr(3'd1, 8'd5);
    rd(3'd0, v); chk("R12 stopped write A", v, 3);
    rd(3'd1, v); chk("R12 stopped write B", v, 5);
    wr(3'd3, 8'h00);
    repeat (10) @(negedge clk);
    rd(3'd1, v); ia = irqa_tot;
    repeat (191) @(negedge clk);
    rd(3'd1, v2);
    chk("R5 chained source", v - v2, 3);
    chk("R2 irq_a pulses per window", irqa_tot - ia, 3);

    // R5 slow source /16
    wr(3'd3, 8'h34);
    wr(3'd1, 8'd7);
    wr(3'd3, 8'h14);
    slow_pulses(16); rd(3'd1, v); chk("R5 slow/16 first", v, 6);
    slow_pulses(15); rd(3'd1, v); chk("R5 slow/16 partial", v, 6);
    slow_pulses(1);  rd(3'd1, v); chk("R5 slow/16 second", v, 5);

    // R5 reserved code 11
    wr(3'd3, 8'h1C);
    pin_pulse(); pin_pulse();
    rd(3'd1, v); chk("R5 code 11 holds", v, 5);

    // R6 edge select (falling selected: rising has no effect)
    wr(3'd3, 8'h18);
    @(negedge clk); cnt_pin = 1'b1; repeat (5) @(negedge clk);
    rd(3'd1, v); chk("R6 rising ignored when falling selected", v, 5);
    cnt_pin = 1'b0; repeat (5) @(negedge clk);
    rd(3'd1, v); chk("R6 falling counted", v, 4);
    wr(3'd4, 8'h08);
    @(negedge clk); cnt_pin = 1'b1; repeat (5) @(negedge clk);
    rd(3'd1, v); chk("R6 rising counted", v, 3);
    cnt_pin = 1'b0; repeat (5) @(negedge clk);
    rd(3'd1, v); chk("R6 falling ignored when rising selected", v, 3);

    // R3 stop / resume
    pin_pulse(); rd(3'd1, v); chk("R3 running counts", v, 2);
    wr(3'd3, 8'h38);
    pin_pulse(); pin_pulse(); pin_pulse();
    rd(3'd1, v); chk("R3 stopped holds", v, 2);
    wr(3'd3, 8'h18);
    pin_pulse(); rd(3'd1, v); chk("R3 resumed", v, 1);

    // R12 running write: latch only
    wr(3'd1, 8'd9);
    rd(3'd1, v); chk("R12 running write keeps count", v, 1);
    pin_pulse(); pin_pulse();
    rd(3'd1, v); chk("R12 new latch at reload", v, 9);

    // R1 R2 R7 random rounds, timer B on pin, rising edge
    for (int r = 0; r < 24; r++) begin
      int np;
      bit en;
      en = ($urandom % 4) != 0;
      m_latch = $urandom % 10;
      np = 1 + ($urandom % 20);
      wr(3'd4, 8'h08);
      wr(3'd3, 8'h38);
      wr(3'd1, 8'(m_latch));
      wr(3'd4, en ? 8'h0A : 8'h08);
      wr(3'd3, 8'h18);
      m_cnt = m_latch; m_tgl = 1'b0; m_irq = 0;
      ib = irqb_tot;
      for (int p = 0; p < np; p++) begin
        pin_pulse();
        step_norm();
      end
      rd(3'd1, v);
      chk("R1 random count", v, m_cnt);
      chk("R2 random irq_b count", irqb_tot - ib, m_irq);
      chk("R7 random out_b", int'(out_b), en ? int'(m_tgl) : 0);
    end

    // R8 R10 PWM n=3 m=2
    wr(3'd3, 8'h38);
    wr(3'd4, 8'h08);
    wr(3'd1, 8'd3);
    wr(3'd2, 8'd2);
    wr(3'd4, 8'h0C);
    wr(3'd3, 8'h18);
    m_latch = 3; m_low = 2; m_cnt = 3; m_hi = 1'b0; m_irq = 0;
    ib = irqb_tot;
    for (int p = 0; p < 16; p++) begin
      pin_pulse();
      step_pwm();
      chk("R8 pwm output level", int'(out_b), int'(m_hi));
    end
    chk("R10 pwm rising-edge requests", irqb_tot - ib, m_irq);
    rd(3'd2, v); chk("R13 low-time readback", v, 2);

    // R9 degenerate widths
    wr(3'd3, 8'h38); wr(3'd1, 8'd0); wr(3'd2, 8'd5); wr(3'd3, 8'h18);
    for (int p = 0; p < 4; p++) begin
      pin_pulse(); chk("R9 n=0 stays low", int'(out_b), 0);
    end
    wr(3'd2, 8'd0);
    pin_pulse(); pin_pulse(); chk("R9 n=0 m=0 low", int'(out_b), 0);
    wr(3'd3, 8'h38); wr(3'd1, 8'd4); wr(3'd3, 8'h18);
    for (int p = 0; p < 4; p++) begin
      pin_pulse(); chk("R9 m=0 stays high", int'(out_b), 1);
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule